// File: doc/BRIEF.md
# Dual Data Pointer Unit with Auto-Step

This block keeps two 16-bit address pointers for an 8-bit controller core, together with one configuration byte. The configuration picks which pointer is the active one and which is the alternate one. It also gives each pointer its own step direction and its own auto-step enable. The core presents the active pointer as the address of external-data and code-table accesses. It raises a use strobe on each such access and, when auto-step is on for that pointer, the pointer moves one position after the access. This lets block-copy loops run without separate pointer arithmetic.

A step command from the core moves either the active or the alternate pointer. That pointer's direction bit turns the command into a decrement when set. The pointer bytes and the configuration byte are reached through the core's special-function-register (SFR) port. Reads are combinational and writes take effect at the next clock. One configuration bit drives a steering output that sends code-table reads and in-application programming accesses to the signature memory instead of code memory.

All pins are plain control and data signals. No stream traffic crosses this block, so it has no valid/ready handshake and never applies back-pressure. The core may raise the strobe, the step command and an SFR write in any cycle, and each is taken in that cycle.

Top module: `dual_dptr_unit`

## Requirements
- R1: After reset, both pointers are 0000h, the configuration byte reads 00h and `sig_sel` is 0.
- R2: The configuration byte sits at SFR address A2h with this layout: bit 7 auto-step enable of pointer 1, bit 6 auto-step enable of pointer 0, bit 5 direction of pointer 1, bit 4 direction of pointer 0, bit 3 signature steering, bit 0 pointer select. Bits 2 and 1 ignore writes and read 0. An SFR read of any address not named in R2 or R4 returns 00h.
- R3: With the select bit at 0, `dptr_act` shows pointer 0 and `dptr_alt` shows pointer 1. With the select bit at 1, the two are swapped.
- R4: SFR address 82h holds the low byte and 83h the high byte of the active pointer, for both read and write. A written byte is visible on `dptr_act` one clock later.
- R5: When `access_stb` is high and the auto-step enable of the active pointer is 1, the active pointer becomes its value plus 1 one clock later if its direction bit is 0, or minus 1 if it is 1. When that enable is 0, the strobe leaves both pointers unchanged.
- R6: `step_cmd` moves the active pointer when `step_alt` is 0 and the alternate pointer when `step_alt` is 1. The move is by that pointer's own direction bit (0 adds 1, 1 subtracts 1), whatever its auto-step enable.
- R7: Steps wrap modulo 2^16: FFFFh plus 1 gives 0000h, and 0000h minus 1 gives FFFFh.
- R8: `sig_sel` equals the signature steering bit of the configuration byte.
- R9: An SFR byte write to a pointer in the same cycle as a step of that same pointer wins. The written byte takes the new value, the other byte keeps its value from before that cycle, and no step is applied.
- R10: A strobe-driven step and a step command aimed at the same pointer in one cycle move it by a single position. When they are aimed at different pointers, both pointers move.
- R11: Within a cycle, steps use the configuration value from before any configuration write made in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| access_stb | input | 1 | External-data or code-table access through the active pointer |
| step_cmd | input | 1 | Step-pointer command |
| step_alt | input | 1 | Step command targets the alternate pointer |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, combinational |
| dptr_act | output | 16 | Active pointer value |
| dptr_alt | output | 16 | Alternate pointer value |
| sig_sel | output | 1 | Steer code-table reads to the signature memory |

## Verification
Two things can fall in the same cycle. A byte write through 82h or 83h can land on a pointer that is also being stepped by the access strobe or by a step command. Two step sources can also hit one pointer or two different pointers at once. The bench drives these overlaps, with pointer values chosen so that a carry or borrow would cross the byte boundary, and after the next clock it checks that the pointer shows exactly the written byte next to the unchanged byte. A second overlap case issues a configuration write together with a strobe, and the check confirms that the step followed the old direction bit.

// File: rtl/dual_dptr_pkg.sv
package dual_dptr_pkg;
  typedef struct packed {
    logic       upd1;
    logic       upd0;
    logic       dn1;
    logic       dn0;
    logic       sig;
    logic [1:0] rsv;
    logic       sel;
  } dptr_cfg_t;

  localparam logic [7:0] CFG_WMASK = 8'hF9;
endpackage

// File: rtl/dptr_cfg.sv
module dptr_cfg
  import dual_dptr_pkg::*;
#(
  parameter logic [7:0] CFG_ADDR = 8'hA2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output dptr_cfg_t  cfg_q
);
  logic hit;
  assign hit = wr_en && (addr == CFG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (hit) cfg_q <= dptr_cfg_t'(wdata & CFG_WMASK);
  end

  AST_CFG_SEL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cfg_q.sel == $past(wdata[0])) && (cfg_q.upd1 == $past(wdata[7]))); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cfg_q)); // R2
endmodule

// File: rtl/dptr_route.sv
module dptr_route
  import dual_dptr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dptr_cfg_t  cfg,
  input  logic       access_stb,
  input  logic       step_cmd,
  input  logic       step_alt,
  output logic [1:0] step_en,
  output logic [1:0] step_dn
);
  logic [1:0] upd_bits;
  logic [1:0] auto_hit;
  logic [1:0] cmd_hit;
  logic       cmd_tgt;

  assign upd_bits = {cfg.upd1, cfg.upd0};
  assign step_dn  = {cfg.dn1, cfg.dn0};
  assign cmd_tgt  = step_alt ? ~cfg.sel : cfg.sel;

  always_comb begin
    auto_hit = '0;
    cmd_hit  = '0;
    if (access_stb && upd_bits[cfg.sel]) auto_hit[cfg.sel] = 1'b1;
    if (step_cmd) cmd_hit[cmd_tgt] = 1'b1;
  end

  assign step_en = auto_hit | cmd_hit;

  AST_CMD_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (step_cmd && !access_stb) |-> ($countones(step_en) == 1)); // R6
  AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_cmd && !access_stb) |-> (step_en == 2'b00)); // R5
  AST_UPD_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (access_stb && !step_cmd && !(cfg.sel ? cfg.upd1 : cfg.upd0)) |-> (step_en == 2'b00)); // R5
endmodule

// File: rtl/dptr_slot.sv
module dptr_slot #(
  parameter int SFR_W = 8,
  parameter int PTR_W = 2 * SFR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             step_dn,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [SFR_W-1:0] wdata,
  output logic [PTR_W-1:0] ptr_q
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] nxt;

  always_comb begin
    nxt = ptr_q;
    if (wr_lo || wr_hi) begin
      if (wr_lo) nxt[SFR_W-1:0] = wdata;
      if (wr_hi) nxt[PTR_W-1:SFR_W] = wdata;
    end else if (step_en) begin
      nxt = step_dn ? (ptr_q - ONE) : (ptr_q + ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= nxt;
  end

  AST_WR_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi && step_en) |=>
      (ptr_q[SFR_W-1:0] == $past(wdata)) &&
      (ptr_q[PTR_W-1:SFR_W] == $past(ptr_q[PTR_W-1:SFR_W]))); // R9
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_dn && !wr_lo && !wr_hi) |=> (ptr_q == $past(ptr_q) + ONE)); // R5
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_dn && !wr_lo && !wr_hi) |=> (ptr_q == $past(ptr_q) - ONE)); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !wr_lo && !wr_hi) |=> $stable(ptr_q)); // R5
endmodule

// File: rtl/dual_dptr_unit.sv
module dual_dptr_unit
  import dual_dptr_pkg::*;
#(
  parameter int         SFR_W    = 8,
  parameter int         PTR_W    = 2 * SFR_W,
  parameter logic [7:0] CFG_ADDR = 8'hA2,
  parameter logic [7:0] LO_ADDR  = 8'h82,
  parameter logic [7:0] HI_ADDR  = 8'h83
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access_stb,
  input  logic             step_cmd,
  input  logic             step_alt,
  input  logic             sfr_wr,
  input  logic [7:0]       sfr_addr,
  input  logic [SFR_W-1:0] sfr_wdata,
  output logic [SFR_W-1:0] sfr_rdata,
  output logic [PTR_W-1:0] dptr_act,
  output logic [PTR_W-1:0] dptr_alt,
  output logic             sig_sel
);
  localparam int NPTR = 2;

  dptr_cfg_t        cfg;
  logic [NPTR-1:0]  step_en;
  logic [NPTR-1:0]  step_dn;
  logic [PTR_W-1:0] ptr [NPTR];

  dptr_cfg #(.CFG_ADDR(CFG_ADDR)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (sfr_wr),
    .addr  (sfr_addr),
    .wdata (8'(sfr_wdata)),
    .cfg_q (cfg)
  );

  dptr_route u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .access_stb (access_stb),
    .step_cmd   (step_cmd),
    .step_alt   (step_alt),
    .step_en    (step_en),
    .step_dn    (step_dn)
  );

  for (genvar i = 0; i < NPTR; i++) begin : g_slot
    logic mine;
    assign mine = (cfg.sel == 1'(i));
    dptr_slot #(.SFR_W(SFR_W), .PTR_W(PTR_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (step_en[i]),
      .step_dn (step_dn[i]),
      .wr_lo   (sfr_wr && mine && (sfr_addr == LO_ADDR)),
      .wr_hi   (sfr_wr && mine && (sfr_addr == HI_ADDR)),
      .wdata   (sfr_wdata),
      .ptr_q   (ptr[i])
    );
  end

  assign dptr_act = cfg.sel ? ptr[1] : ptr[0];
  assign dptr_alt = cfg.sel ? ptr[0] : ptr[1];
  assign sig_sel  = cfg.sig;

  always_comb begin
    sfr_rdata = '0;
    if (sfr_addr == CFG_ADDR)     sfr_rdata = SFR_W'(cfg);
    else if (sfr_addr == LO_ADDR) sfr_rdata = dptr_act[SFR_W-1:0];
    else if (sfr_addr == HI_ADDR) sfr_rdata = dptr_act[PTR_W-1:SFR_W];
  end

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == CFG_ADDR) |-> (sfr_rdata[2:1] == 2'b00)); // R2
  AST_SIG_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == CFG_ADDR) |=> (sig_sel == $past(sfr_wdata[3]))); // R8
  AST_LO_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == LO_ADDR) |=> (dptr_act[SFR_W-1:0] == $past(sfr_wdata))); // R4
endmodule

// File: tb/test_dual_dptr_unit.sv
module test_dual_dptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        access_stb = 1'b0, step_cmd = 1'b0, step_alt = 1'b0, sfr_wr = 1'b0;
  logic [7:0]  sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic [15:0] dptr_act, dptr_alt;
  logic        sig_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] m0 = 16'h0000, m1 = 16'h0000;
  logic [7:0]  mc = 8'h00;

  logic [15:0] q_act[$];
  logic [15:0] q_alt[$];
  logic        q_sig[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  dual_dptr_unit i_dual_dptr_unit (
    .clk(clk), .rst_n(rst_n), .access_stb(access_stb), .step_cmd(step_cmd),
    .step_alt(step_alt), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .dptr_act(dptr_act), .dptr_alt(dptr_alt), .sig_sel(sig_sel)
  );

  task automatic check16(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Monitor: pops one expected item per cycle after the driver pushed it.
  always @(negedge clk) begin
    if (q_act.size() > 0) begin
      logic [15:0] ea, eb;
      logic es;
      string t;
      ea = q_act.pop_front();
      eb = q_alt.pop_front();
      es = q_sig.pop_front();
      t  = q_tag.pop_front();
      check16(dptr_act, ea, {t, " act"});
      check16(dptr_alt, eb, {t, " alt"});
      check16({15'd0, sig_sel}, {15'd0, es}, {t, " sig"});
    end
  end

  // Driver: one cycle of stimulus; updates the model and pushes the expectation.
  task automatic cyc(input logic stb, input logic cmd, input logic alt,
                     input logic wr, input logic [7:0] a, input logic [7:0] d,
                     input string tag);
    logic sel;
    logic [1:0] st;
    logic tgt;
    logic [15:0] n0, n1;
    logic [7:0] nc;
    @(negedge clk);
    access_stb = stb; step_cmd = cmd; step_alt = alt;
    sfr_wr = wr; sfr_addr = a; sfr_wdata = d;
    sel = mc[0];
    st = 2'b00;
    if (stb && (sel ? mc[7] : mc[6])) st[sel] = 1'b1;
    if (cmd) begin
      tgt = alt ? ~sel : sel;
      st[tgt] = 1'b1;
    end
    n0 = st[0] ? (mc[4] ? m0 - 16'd1 : m0 + 16'd1) : m0;
    n1 = st[1] ? (mc[5] ? m1 - 16'd1 : m1 + 16'd1) : m1;
    nc = mc;
    if (wr && (a == 8'h82 || a == 8'h83)) begin
      if (sel == 1'b0) begin
        n0 = m0;
        if (a == 8'h82) n0[7:0] = d; else n0[15:8] = d;
      end else begin
        n1 = m1;
        if (a == 8'h82) n1[7:0] = d; else n1[15:8] = d;
      end
    end
    if (wr && a == 8'hA2) nc = d & 8'hF9;
    m0 = n0; m1 = n1; mc = nc;
    @(posedge clk);
    #1;
    access_stb = 1'b0; step_cmd = 1'b0; step_alt = 1'b0; sfr_wr = 1'b0;
    q_act.push_back(mc[0] ? m1 : m0);
    q_alt.push_back(mc[0] ? m0 : m1);
    q_sig.push_back(mc[3]);
    q_tag.push_back(tag);
  endtask

  task automatic wcfg(input logic [7:0] d, input string tag);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'hA2, d, tag);
  endtask

  task automatic wptr(input logic [15:0] v, input string tag);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h82, v[7:0], tag);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h83, v[15:8], tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    sfr_addr = a;
    #2;
    check16({8'd0, sfr_rdata}, {8'd0, exp}, tag);
    sfr_addr = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check16(dptr_act, 16'h0000, "R1 act in reset");
    check16(dptr_alt, 16'h0000, "R1 alt in reset");
    check16({15'd0, sig_sel}, 16'h0000, "R1 sig in reset");
    @(negedge clk);
    rst_n = 1'b1;
    rd(8'hA2, 8'h00, "R1 cfg reset");
    rd(8'h82, 8'h00, "R1 low reset");
    rd(8'h55, 8'h00, "R2 unmapped read");

    // R4: byte load of pointer 0, then pointer 1 via select (R3)
    wptr(16'h12FF, "R4 load ptr0");
    rd(8'h82, 8'hFF, "R4 read low");
    rd(8'h83, 8'h12, "R4 read high");
    wcfg(8'h01, "R3 select ptr1");
    wptr(16'hFFFF, "R4 load ptr1");
    wcfg(8'h00, "R3 select ptr0");

    // R5: strobe with auto-step off then on
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R5 stb upd off");
    wcfg(8'h40, "R5 upd0 up");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R5 stb inc carry");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R5 stb inc");
    wcfg(8'h50, "R5 upd0 down");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R5 stb dec");

    // R6 / R7: step commands on active and alternate pointer
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R6 cmd active down");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R7 cmd alt wrap up");
    wcfg(8'h10, "R6 upd off dn0");
    wptr(16'h0000, "R7 ptr0 zero");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R7 cmd wrap down");

    // R3: swap with pointer 1 active, R5 auto-step on pointer 1
    wcfg(8'hA1, "R3 sel1 upd1 dn1");
    rd(8'h82, 8'h00, "R3 low of ptr1");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R5 ptr1 dec wrap");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R6 cmd alt ptr0");

    // R9: byte write together with a step on the same pointer
    wptr(16'h00FF, "R9 preload");
    wcfg(8'h81, "R9 ptr1 up");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h83, 8'h3C, "R9 high write beats stb");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h82, 8'h5A, "R9 low write beats cmd");

    // R10: two step sources
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R10 same pointer single");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R10 both pointers");

    // R11: cfg write with strobe uses old direction
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'hA2, 8'hA1, "R11 old cfg used");

    // R2 / R8: reserved bits and signature steering
    wcfg(8'hFF, "R8 sig on");
    rd(8'hA2, 8'hF9, "R2 reserved read zero");
    wcfg(8'h00, "R8 sig off");
    rd(8'hA2, 8'h00, "R2 cleared");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule